// File: doc/BRIEF.md
# 16-bit Compare-Match PWM Channel

This block is one compare channel of a timer array, configured as a 16-bit pulse-width modulator. It watches a free-running 16-bit timebase that lives outside the block, supplied as the counter's present value plus a one-cycle tick that marks each advance. When the counter reaches the programmed compare value, the output pin goes high. When the counter wraps from its top value back to zero, the pin goes low. The compare value is therefore the length of the low phase in timebase counts, and the duty cycle is (65536 − compare) / 65536.

Software reaches the channel through a byte-wide register port with three locations: the low compare byte, the high compare byte and a control byte. The compare bytes interlock with the comparator enable. Writing the low byte disarms the comparator and writing the high byte re-arms it, so a half-written compare value never produces a match. A match sets a sticky flag. When the flag's interrupt enable is set, the flag raises an interrupt request, which lets software load the next duty value at a safe point in the period.

All events are timed against the counter's new value. A tick with counter value `v` moves the counter to `v+1`. A match event is a tick where `v+1` equals the compare value. A wrap event is a tick where `v` is 0xFFFF. The output register takes the result on that same clock edge.

Top module: `pwm16_channel`

## Requirements
- R1: With the enable, PWM and wide bits all set, a tick whose counter value plus one equals the compare value drives `pwm_out` high on that clock edge.
- R2: A tick with counter value 0xFFFF drives `pwm_out` low on that edge when the PWM and wide bits are both set, whatever the enable bit is. If either of those two bits is clear, the wrap leaves the output unchanged.
- R3: With compare value C and one tick per cycle, `pwm_out` is high for exactly 65536 − C of the 65536 ticks in a full period.
- R4: With compare value 0, the match and the wrap fall on the same tick and the match wins, so the output stays high (100% duty).
- R5: A write to address 0 (compare bits 7:0) clears the enable bit (control bit 0) on the next edge.
- R6: A write to address 1 (compare bits 15:8) sets the enable bit on the next edge.
- R7: While the enable bit is 0, a tick that would match neither changes `pwm_out` nor sets the match flag.
- R8: A match sets the match flag (control bit 7). The flag stays set until a control write with bit 7 = 0 clears it. A control write with bit 7 = 1 leaves the flag unchanged.
- R9: `irq` is high exactly when the match flag and the interrupt-enable bit (control bit 3) are both 1.
- R10: In a cycle without a tick, nothing happens to `pwm_out`, even when the counter value equals compare − 1.
- R11: Register map: address 0 holds the low compare byte, address 1 the high compare byte, address 2 the control byte. In the control byte, bit 0 is enable, bit 1 is PWM select, bit 2 is wide (16-bit) select, bit 3 is interrupt enable and bit 7 is the match flag; every other bit reads 0. Reset clears all registers, `pwm_out` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbase_count | input | 16 | Present value of the shared timebase counter |
| tbase_tick | input | 1 | Timebase advances on this edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low byte, 1 high byte, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Match interrupt request |

## Verification
The hardest case to reach is a full-period duty measurement. Sweeping all 65536 counter values is slow, so the bench drives the timebase value itself. It jumps straight to the counts just below a match or a wrap for single-event checks. It runs one unbroken sweep from a wrap only to count the high ticks against 65536 − C. The disarmed-hold case is reached by writing only the low byte right after a match has raised the output. The next tick that would match then must leave the output high, and the following wrap must still pull it low.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
    // control byte bit positions
    localparam int EN_BIT   = 0;
    localparam int PWM_BIT  = 1;
    localparam int WIDE_BIT = 2;
    localparam int IE_BIT   = 3;
    localparam int FLAG_BIT = 7;

    typedef struct packed {
        logic flag;
        logic ie;
        logic wide;
        logic pwm;
        logic en;
    } ctl_t;
endpackage

// File: rtl/pwm16_regs.sv
module pwm16_regs
    import pwm16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    localparam int NB    = CNT_W / DATA_W,
    localparam int AW    = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic              match_evt,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              cmp_en,
    output logic              pwm_sel,
    output logic              wide_sel,
    output logic              int_en,
    output logic              match_flag
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NB);
    localparam logic [AW-1:0] TOP_ADDR  = AW'(NB - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        ctl_t             ctl;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_addr == AW'(b))
                    st_d.cmp[b*DATA_W +: DATA_W] = wr_data;
            end
            if (wr_addr == '0)
                st_d.ctl.en = 1'b0;          // disarm on low byte
            else if (wr_addr == TOP_ADDR)
                st_d.ctl.en = 1'b1;          // re-arm on high byte
            if (wr_addr == CTRL_ADDR) begin
                st_d.ctl.en   = wr_data[EN_BIT];
                st_d.ctl.pwm  = wr_data[PWM_BIT];
                st_d.ctl.wide = wr_data[WIDE_BIT];
                st_d.ctl.ie   = wr_data[IE_BIT];
                st_d.ctl.flag = st_q.ctl.flag & wr_data[FLAG_BIT];
            end
        end
        if (match_evt)
            st_d.ctl.flag = 1'b1;            // hardware set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == AW'(b))
                rd_data = st_q.cmp[b*DATA_W +: DATA_W];
        end
        if (rd_addr == CTRL_ADDR) begin
            rd_data[EN_BIT]   = st_q.ctl.en;
            rd_data[PWM_BIT]  = st_q.ctl.pwm;
            rd_data[WIDE_BIT] = st_q.ctl.wide;
            rd_data[IE_BIT]   = st_q.ctl.ie;
            rd_data[FLAG_BIT] = st_q.ctl.flag;
        end
    end

    assign cmp_val    = st_q.cmp;
    assign cmp_en     = st_q.ctl.en;
    assign pwm_sel    = st_q.ctl.pwm;
    assign wide_sel   = st_q.ctl.wide;
    assign int_en     = st_q.ctl.ie;
    assign match_flag = st_q.ctl.flag;
endmodule

// File: rtl/pwm16_evt.sv
module pwm16_evt #(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_en,
    input  logic             pwm_sel,
    input  logic             wide_sel,
    output logic             match_evt,
    output logic             wrap_evt
);
    logic [CNT_W-1:0] count_nxt;
    logic             mode_on;

    always_comb begin
        count_nxt = count + CNT_W'(1);
        mode_on   = pwm_sel & wide_sel;
        match_evt = tick & mode_on & cmp_en & (count_nxt == cmp_val);
        wrap_evt  = tick & mode_on & (&count);
    end
endmodule

// File: rtl/pwm16_outq.sv
module pwm16_outq (
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt,
    input  logic wrap_evt,
    output logic pwm_out
);
    typedef struct packed {
        logic lvl;
    } out_st_t;

    out_st_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (match_evt)     o_d.lvl = 1'b1;   // match has priority
        else if (wrap_evt) o_d.lvl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pwm_out = o_q.lvl;
endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    localparam int NB    = CNT_W / DATA_W,
    localparam int AW    = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tbase_count,
    input  logic              tbase_tick,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              irq
);
    logic [CNT_W-1:0] cmp_val;
    logic cmp_en, pwm_sel, wide_sel, int_en, match_flag;
    logic match_evt, wrap_evt;

    pwm16_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .match_evt  (match_evt),
        .rd_data    (rd_data),
        .cmp_val    (cmp_val),
        .cmp_en     (cmp_en),
        .pwm_sel    (pwm_sel),
        .wide_sel   (wide_sel),
        .int_en     (int_en),
        .match_flag (match_flag)
    );

    pwm16_evt #(.CNT_W(CNT_W)) u_evt (
        .tick      (tbase_tick),
        .count     (tbase_count),
        .cmp_val   (cmp_val),
        .cmp_en    (cmp_en),
        .pwm_sel   (pwm_sel),
        .wide_sel  (wide_sel),
        .match_evt (match_evt),
        .wrap_evt  (wrap_evt)
    );

    pwm16_outq u_outq (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_evt (match_evt),
        .wrap_evt  (wrap_evt),
        .pwm_out   (pwm_out)
    );

    assign irq = match_flag & int_en;
endmodule

// File: rtl/pwm16_chk.sv
module pwm16_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    localparam int NB    = CNT_W / DATA_W,
    localparam int AW    = $clog2(NB + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tbase_count,
    input logic             tbase_tick,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic             pwm_out,
    input logic             irq,
    input logic [CNT_W-1:0] cmp_val,
    input logic             cmp_en,
    input logic             pwm_sel,
    input logic             wide_sel,
    input logic             match_flag
);
    logic would_match, at_top, mode_on, ctl_wr;
    assign mode_on     = pwm_sel && wide_sel;
    assign would_match = tbase_tick && mode_on && ((tbase_count + CNT_W'(1)) == cmp_val);
    assign at_top      = tbase_tick && (&tbase_count);
    assign ctl_wr      = wr_en && (wr_addr == AW'(NB));

    assert_match_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        would_match && cmp_en |=> pwm_out);

    assert_wrap_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        at_top && mode_on && !(cmp_en && cmp_val == '0) |=> !pwm_out);

    assert_zero_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        at_top && mode_on && cmp_en && cmp_val == '0 |=> pwm_out);

    assert_lowbyte_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == '0 |=> !cmp_en);

    assert_highbyte_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == AW'(NB - 1) |=> cmp_en);

    assert_disarmed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tbase_tick && !cmp_en && !(at_top && mode_on) |=> $stable(pwm_out));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        would_match && cmp_en |=> match_flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match_flag && !ctl_wr |=> match_flag);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !match_flag |-> !irq);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tbase_tick |=> $stable(pwm_out));
endmodule

bind pwm16_channel pwm16_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbase_count (tbase_count),
    .tbase_tick  (tbase_tick),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .pwm_out     (pwm_out),
    .irq         (irq),
    .cmp_val     (cmp_val),
    .cmp_en      (cmp_en),
    .pwm_sel     (pwm_sel),
    .wide_sel    (wide_sel),
    .match_flag  (match_flag)
);

// File: tb/sim_pwm16_channel.sv
module sim_pwm16_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tbase_count = '0;
    logic        tbase_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        pwm_out, irq;

    pwm16_channel u0 (
        .clk(clk), .rst_n(rst_n), .tbase_count(tbase_count), .tbase_tick(tbase_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       req;
        int          sel;   // 0 pwm_out, 1 irq, 2 rd_data
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic void check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    // monitor: compares queued expectations just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                case (it.sel)
                    0:       check(it.req, {15'd0, pwm_out}, it.exp);
                    1:       check(it.req, {15'd0, irq}, it.exp);
                    default: check(it.req, {8'd0, rd_data}, it.exp);
                endcase
            end
        end
    end

    task automatic expect_item(string req, int sel, logic [15:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    task automatic cyc(logic we, logic [1:0] wa, logic [7:0] wd, logic tk, logic [15:0] cv);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        tbase_tick = tk; tbase_count = cv;
        @(posedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 16'h0000);
    endtask

    task automatic tk(logic [15:0] v);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, v);
    endtask

    task automatic idle(logic [15:0] v);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, v);
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] e, string req);
        @(negedge clk);
        rd_addr = a;
        idle(16'h0000);
        expect_item(req, 2, {8'd0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state and map
        idle(16'h0000);
        expect_item("R11 reset pwm", 0, 16'd0);
        expect_item("R11 reset irq", 1, 16'd0);
        rd(2'd0, 8'h00, "R11 reset low");
        rd(2'd1, 8'h00, "R11 reset high");
        rd(2'd2, 8'h00, "R11 reset ctrl");

        // arm with compare 0x0010
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h10);
        rd(2'd2, 8'h06, "R5 low write disarms");
        wr(2'd1, 8'h00);
        rd(2'd2, 8'h07, "R6 high write arms");
        rd(2'd0, 8'h10, "R11 low byte readback");

        // R1 match
        tk(16'h000E); expect_item("R1 pre-match low", 0, 16'd0);
        tk(16'h000F); expect_item("R1 match high", 0, 16'd1);
        rd(2'd2, 8'h87, "R8 flag set by match");
        expect_item("R9 irq off without enable", 1, 16'd0);

        // R2 wrap
        tk(16'hFFFF); expect_item("R2 wrap low", 0, 16'd0);

        // R10 no tick at match-1
        idle(16'h000F); idle(16'h000F); idle(16'h000F);
        expect_item("R10 no tick no change", 0, 16'd0);
        rd(2'd2, 8'h87, "R8 flag sticky");

        // R8/R9 flag write semantics and irq
        wr(2'd2, 8'h8F); expect_item("R9 irq high", 1, 16'd1);
        rd(2'd2, 8'h8F, "R8 writing 1 keeps flag");
        wr(2'd2, 8'h0F); expect_item("R9 irq cleared", 1, 16'd0);
        rd(2'd2, 8'h0F, "R8 writing 0 clears flag");
        wr(2'd2, 8'h07);

        // R7 disarmed hold
        tk(16'h000F); expect_item("R1 match again", 0, 16'd1);
        wr(2'd0, 8'h20);
        rd(2'd2, 8'h86, "R5 disarm keeps flag");
        tk(16'h001F); expect_item("R7 disarmed hold high", 0, 16'd1);
        tk(16'hFFFF); expect_item("R2 wrap clears while disarmed", 0, 16'd0);
        wr(2'd2, 8'h06);
        tk(16'h001F); expect_item("R7 disarmed hold low", 0, 16'd0);
        rd(2'd2, 8'h06, "R7 no flag while disarmed");
        wr(2'd1, 8'h00);
        tk(16'h001F); expect_item("R6 re-armed match", 0, 16'd1);

        // R2 mode bits off: wrap ignored
        wr(2'd2, 8'h01);
        tk(16'hFFFF); expect_item("R2 wrap ignored without mode bits", 0, 16'd1);
        wr(2'd2, 8'h07);
        tk(16'hFFFF); expect_item("R2 wrap low", 0, 16'd0);

        // R4 compare zero
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        tk(16'hFFFF); expect_item("R4 zero compare high at wrap", 0, 16'd1);
        tk(16'h0000); tk(16'h7FFF);
        expect_item("R4 stays high", 0, 16'd1);
        tk(16'hFFFF); expect_item("R4 stays high at next wrap", 0, 16'd1);

        // R3 duty with compare 0x4000
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h40);
        tk(16'hFFFF); expect_item("R3 period start low", 0, 16'd0);
        @(negedge clk);
        hi = 0;
        for (int i = 0; i < 65536; i++) begin
            tk(i[15:0]);
            #1;
            if (pwm_out) hi++;
        end
        check("R3 high ticks per period", hi[15:0], 16'(65536 - 16'h4000));
        check("R3 low after wrap", {15'd0, pwm_out}, 16'd0);

        repeat (3) idle(16'h0000);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule